// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus when a target device is stuck holding SDA low. It watches the sampled SCL and SDA levels. When a recover command arrives and SDA reads low, it drives SCL low and then releases it, one pulse per timing period. It does this until the target lets go of SDA or until a fixed pulse limit is reached. When the sequence ends, a sticky recovery-done status bit is raised. Software clears that bit by writing a one to it.

Each SCL pulse lasts two timing periods set by an external tick: one low period and one released period. The released period is extended for as long as the line still reads low, so a target that stretches the clock is respected. SDA is sampled only at the end of a released period, and only while SCL reads high. The block also gives live status outputs: the registered SCL and SDA levels, and a bus-busy flag that is high unless both lines read high.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset, scl_drive_low, busy and done_irq are 0, and scl_level and sda_level are 1.
- R2: A recover_req with SDA reading low starts a pulse train. SCL is driven low until the next tick, then released, and scl_drive_low falls only in the cycle after a tick.
- R3: SDA is sampled at the end of each released phase. If it reads high there, the sequence stops after that pulse, so the pulse count equals the number of pulses the target needed.
- R4: No more than MAX_PULSES (default 8) pulses are issued. If SDA still reads low after the last pulse, the sequence stops anyway.
- R5: done_irq is set when a sequence ends, including the case where SDA already reads high at the command. In that case no pulse is issued.
- R6: A one-cycle done_clr clears done_irq. If a set and a clear happen in the same cycle, the set wins and done_irq stays 1.
- R7: A recover_req that arrives while busy is 1 has no effect. The running sequence neither restarts nor extends.
- R8: While SCL reads low during a released phase (clock stretching), the phase is held. No new pulse starts and SDA is not evaluated.
- R9: scl_level and sda_level follow scl_in and sda_in one cycle later. bus_busy is 1 unless both registered levels are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recover_req | input | 1 | One-cycle recover command |
| done_clr | input | 1 | Write-one-to-clear strobe for done_irq |
| tick | input | 1 | SCL phase timing tick, one cycle wide |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| busy | output | 1 | Recovery sequence in progress |
| done_irq | output | 1 | Sticky recovery-done status bit |
| scl_level | output | 1 | Registered SCL level |
| sda_level | output | 1 | Registered SDA level |
| bus_busy | output | 1 | Line-level busy: not both lines high |

## Verification
Two situations are hard to reach from the ports. The first is a target that stretches SCL during a released phase. The second is a second recover command that lands in the middle of a running sequence. The bench models the bus itself: SCL follows the drive output unless a stretch override pulls it low, and SDA is released after a programmed number of observed pulses. This lets it hold the line low part-way through a pulse train and check that no pulse advances. It also lets it keep SDA low for the whole run and send a second command mid-run, so that a restart would show up as more than eight pulses.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } rec_state_e;
endpackage

// File: rtl/unstick_line_sampler.sv
module unstick_line_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_q,
  output logic sda_q,
  output logic line_busy
);
  logic scl_d, sda_d;

  always_comb begin
    scl_d = scl_in;
    sda_d = sda_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  // idle only when both lines read high
  assign line_busy = ~(scl_q & sda_q);
endmodule

// File: rtl/unstick_pulse_counter.sv
module unstick_pulse_counter #(
  parameter int MAX_PULSES = 8,
  localparam int CNT_W = $clog2(MAX_PULSES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = cnt;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  assign at_last = (cnt == CNT_W'(MAX_PULSES - 1));

  assert_cnt_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_PULSES));
endmodule

// File: rtl/unstick_fsm.sv
module unstick_fsm
  import i2c_unstick_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic tick,
  input  logic scl_q,
  input  logic sda_q,
  input  logic at_last,
  output logic start,
  output logic inc,
  output logic fin,
  output logic drive_low,
  output logic busy
);
  rec_state_e state_q, state_d;
  logic       drive_d;

  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    inc     = 1'b0;
    fin     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          if (sda_q) begin
            fin = 1'b1;            // nothing to free
          end else begin
            start   = 1'b1;
            state_d = ST_LOW;
          end
        end
      end
      ST_LOW: begin
        if (tick) state_d = ST_HIGH;
      end
      ST_HIGH: begin
        // held while the line is stretched low
        if (tick && scl_q) begin
          inc = 1'b1;
          if (sda_q || at_last) begin
            fin     = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_LOW;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    drive_d = (state_d == ST_LOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      drive_low <= 1'b0;
    end else begin
      state_q   <= state_d;
      drive_low <= drive_d;
    end
  end

  assign busy = (state_q != ST_IDLE);

  assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_low) |-> $past(tick));
  assert_drive_implies_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> busy);
endmodule

// File: rtl/unstick_done_flag.sv
module unstick_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_d, flag_en;

  always_comb begin
    flag_en = set | clr;
    flag_d  = set ? 1'b1 : 1'b0;   // set wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (flag_en) flag <= flag_d;
  end

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick #(
  parameter int MAX_PULSES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recover_req,
  input  logic done_clr,
  input  logic tick,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_drive_low,
  output logic busy,
  output logic done_irq,
  output logic scl_level,
  output logic sda_level,
  output logic bus_busy
);
  localparam int CNT_W = $clog2(MAX_PULSES + 1);

  logic             scl_q, sda_q;
  logic             start, inc, fin, at_last;
  logic [CNT_W-1:0] pulse_cnt;

  unstick_line_sampler u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .line_busy (bus_busy)
  );

  unstick_pulse_counter #(.MAX_PULSES(MAX_PULSES)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start),
    .inc     (inc),
    .cnt     (pulse_cnt),
    .at_last (at_last)
  );

  unstick_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (recover_req),
    .tick      (tick),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .at_last   (at_last),
    .start     (start),
    .inc       (inc),
    .fin       (fin),
    .drive_low (scl_drive_low),
    .busy      (busy)
  );

  unstick_done_flag u_done (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (fin),
    .clr   (done_clr),
    .flag  (done_irq)
  );

  assign scl_level = scl_q;
  assign sda_level = sda_q;

  assert_done_on_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_irq);
  assert_count_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_cnt != $past(pulse_cnt) && pulse_cnt != '0) |-> !$past(scl_drive_low));
endmodule

// File: tb/i2c_bus_unstick_test.sv
module i2c_bus_unstick_test;
  localparam int TICK_DIV = 5;
  localparam int VEC_N = 7;
  // high nibble: pulses before target releases SDA, low nibble: expected pulses
  localparam logic [7:0] VEC [VEC_N] = '{8'h11, 8'h33, 8'h88, 8'h98, 8'hF8, 8'h00, 8'h55};

  logic clk = 1'b0, rst_n = 1'b0;
  logic recover_req = 1'b0, done_clr = 1'b0, tick = 1'b0, stretch = 1'b0;
  logic scl_in, sda_in;
  logic scl_drive_low, busy, done_irq, scl_level, sda_level, bus_busy;
  int ptotal = 0, pbase = 0, rel_q = 0;
  int nchk = 0, nfail = 0, cyc = 0;

  always #10 clk = ~clk;

  i2c_bus_unstick uut (
    .clk(clk), .rst_n(rst_n), .recover_req(recover_req), .done_clr(done_clr),
    .tick(tick), .scl_in(scl_in), .sda_in(sda_in), .scl_drive_low(scl_drive_low),
    .busy(busy), .done_irq(done_irq), .scl_level(scl_level), .sda_level(sda_level),
    .bus_busy(bus_busy)
  );

  assign scl_in = ~scl_drive_low & ~stretch;
  assign sda_in = ((ptotal - pbase) >= rel_q);

  always @(posedge scl_drive_low) ptotal <= ptotal + 1;

  initial forever begin
    repeat (TICK_DIV - 1) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nfail + 1);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk) recover_req = 1'b1;
    @(negedge clk) recover_req = 1'b0;
  endtask

  task automatic wait_idle(string tag);
    int g = 0;
    repeat (2) @(negedge clk);
    while (busy && g < 2000) begin
      @(negedge clk);
      g++;
    end
    chk({tag, " finish"}, (g < 2000) ? 1 : 0, 1);
  endtask

  task automatic clear_done();
    @(negedge clk) done_clr = 1'b1;
    @(negedge clk) done_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 drive", scl_drive_low, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done_irq, 0);
    chk("R1 levels", {scl_level, sda_level}, 2'b11);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3/R4/R5 table walk
    for (int i = 0; i < VEC_N; i++) begin
      int rel, exp;
      rel = int'(VEC[i][7:4]);
      exp = int'(VEC[i][3:0]);
      pbase = ptotal;
      rel_q = rel;
      pulse_req();
      wait_idle("R3 vec");
      chk(exp == 8 ? "R4 pulse limit" : "R3 pulse count", ptotal - pbase, exp);
      chk("R5 done set", done_irq, 1);
      chk("R2 drive released", scl_drive_low, 0);
      clear_done();
      chk("R6 done cleared", done_irq, 0);
    end

    // R2: first pulse drives low, then released
    pbase = ptotal; rel_q = 2;
    pulse_req();
    chk("R2 drive low", scl_drive_low, 1);
    chk("R2 busy", busy, 1);
    wait_idle("R2 run");
    chk("R2 pulses", ptotal - pbase, 2);
    clear_done();

    // R8: stretch during released phase
    pbase = ptotal; rel_q = 2;
    pulse_req();
    begin
      int g = 0;
      while (!((ptotal - pbase) >= 1 && !scl_drive_low) && g < 500) begin
        @(negedge clk); g++;
      end
    end
    stretch = 1'b1;
    begin
      bit drove = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (scl_drive_low) drove = 1;
      end
      chk("R8 no pulse while stretched", drove, 0);
    end
    chk("R8 count held", ptotal - pbase, 1);
    chk("R8 busy held", busy, 1);
    stretch = 1'b0;
    wait_idle("R8 run");
    chk("R8 pulses after stretch", ptotal - pbase, 2);
    clear_done();

    // R7: repeat command mid-run ignored (SDA never released)
    pbase = ptotal; rel_q = 12;
    pulse_req();
    repeat (23) @(negedge clk);
    chk("R7 busy before repeat", busy, 1);
    pulse_req();
    wait_idle("R7 run");
    chk("R7 no restart", ptotal - pbase, 8);
    clear_done();

    // R6: set and clear in the same cycle
    pbase = ptotal; rel_q = 0;
    pulse_req();
    @(negedge clk);
    chk("R6 done before", done_irq, 1);
    recover_req = 1'b1; done_clr = 1'b1;
    @(negedge clk);
    recover_req = 1'b0; done_clr = 1'b0;
    chk("R6 set wins", done_irq, 1);
    chk("R5 zero pulses", ptotal - pbase, 0);
    clear_done();

    // R9: live line status
    pbase = ptotal; rel_q = 1;
    repeat (2) @(negedge clk);
    chk("R9 sda low", sda_level, 0);
    chk("R9 scl high", scl_level, 1);
    chk("R9 bus busy", bus_busy, 1);
    rel_q = 0;
    repeat (2) @(negedge clk);
    chk("R9 sda high", sda_level, 1);
    chk("R9 bus idle", bus_busy, 0);
    stretch = 1'b1;
    @(negedge clk);
    chk("R9 scl one cycle late", scl_level, 0);
    stretch = 1'b0;
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule